// File: doc/BRIEF.md
# Finite-Difference Polynomial Tabulator

This block produces successive values of a polynomial of degree up to six without any multiplier. It keeps a cascade of seven registers: the function value and six difference orders above it. On every step each order below the top adds in the order directly above it, and the top order stays constant. All orders update at the same clock edge from the values they held before that step. One adder per order therefore yields one new table entry per cycle.

Before a run, software writes the starting function value and the starting differences through a simple select/value load port. A start pulse with a non-zero entry count then sets the engine running. It emits one value per cycle, together with a valid strobe and the table index n. When the last entry appears the engine reports completion and keeps all its state. A later start carries on the table from where it stopped. Arithmetic wraps modulo 2^DATA_W, and a sticky flag records any carry out of any order during a run.

Top module: `diff_table_engine`

## Requirements
- R1: While not busy, a cycle with `load_i` high writes `load_val_i` into order `load_sel_i`, where 0 is the function value and 1..6 are difference orders. A select value above 6 changes nothing. Any accepted load clears `done_o`.
- R2: A start (`start_i` high while not busy, with `count_i` non-zero) raises `busy_o` after the next edge. From the edge after that, `valid_o` is high on exactly `count_i` consecutive cycles and then falls.
- R3: Each valid `value_o` is the current order 0. On every step all orders update together: order k becomes order k plus order k+1 (k = 0..5), and order 6 is held. Loading 41, 2, 2 into orders 0, 1, 2 gives 41, 43, 47, 53, 61.
- R4: `index_o` reads 0 on the first valid entry of a run and rises by one on each following entry.
- R5: `done_o` rises in the same cycle as the last valid entry. It stays high until an accepted load or a start, and it is never high together with `busy_o`.
- R6: After completion all orders are held. A new start continues the table from the next value, with the index restarting at 0.
- R7: Additions wrap modulo 2^DATA_W. `ovf_o` becomes high after any step in which any order's addition carries out. It stays high until the next start, which clears it.
- R8: `load_i` and `start_i` are ignored while busy.
- R9: A start with `count_i` equal to zero has no effect.
- R10: After reset every order is zero, and `valid_o`, `busy_o`, `done_o`, `ovf_o`, `index_o` and `value_o` are zero.
- R11: With all seven orders loaded with arbitrary values, every output matches the finite-difference recurrence of R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Write strobe for one order register |
| load_sel_i | input | 3 | Order to write (0 = function value, 1..6 = differences) |
| load_val_i | input | DATA_W | Value to write |
| start_i | input | 1 | Begin a run |
| count_i | input | CNT_W | Number of entries to produce |
| value_o | output | DATA_W | Table value |
| valid_o | output | 1 | Table value present this cycle |
| index_o | output | CNT_W | Index n of the current entry |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run completed, state held |
| ovf_o | output | 1 | Carry out seen in some order during this run |

## Verification
The bench targets the ordering of the cascade update. A design that updated the orders one after another would let order 0 pick up an already advanced first difference, which skews the table from the second entry on (43 would become 45). Single-entry runs, zero-count starts and restarts after completion probe the end-of-run bookkeeping. An off-by-one counter there would emit one entry too many, raise done a cycle late, or lose the held state. Loads and starts injected mid-run check that the datapath ignores them, and sums forced past 2^48 check both the wrap and the sticky carry flag, including its clearing on the next start.

// File: rtl/diff_eng_pkg.sv
package diff_eng_pkg;
  localparam int unsigned DEF_DATA_W = 48;
  localparam int unsigned DEF_ORDERS = 6;
  localparam int unsigned DEF_CNT_W  = 16;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } run_state_e;
endpackage

// File: rtl/diff_order_reg.sv
module diff_order_reg #(
  parameter int unsigned DATA_W = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_en_i,
  input  logic [DATA_W-1:0] load_val_i,
  input  logic              step_i,
  input  logic [DATA_W-1:0] upper_i,
  output logic [DATA_W-1:0] val_o,
  output logic              carry_o
);
  logic [DATA_W:0] sum;

  assign sum     = {1'b0, val_o} + {1'b0, upper_i};
  assign carry_o = sum[DATA_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        val_o <= '0;
    else if (load_en_i) val_o <= load_val_i;
    else if (step_i)    val_o <= sum[DATA_W-1:0];
  end
endmodule

// File: rtl/diff_step_ctrl.sv
module diff_step_ctrl
  import diff_eng_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             carry_any_i,
  output logic             step_o,
  output logic             load_ok_o,
  output logic [CNT_W-1:0] n_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             ovf_o
);
  run_state_e       state_q;
  logic [CNT_W-1:0] rem_q;
  logic             go;

  assign busy_o    = (state_q == ST_RUN);
  assign done_o    = (state_q == ST_DONE);
  assign step_o    = busy_o;
  assign load_ok_o = load_i && !busy_o;
  assign go        = start_i && !busy_o && (count_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      n_o     <= '0;
      ovf_o   <= 1'b0;
    end else begin
      case (state_q)
        ST_RUN: begin
          n_o   <= n_o + 1'b1;
          rem_q <= rem_q - 1'b1;
          if (carry_any_i) ovf_o <= 1'b1;
          if (rem_q == CNT_W'(1)) state_q <= ST_DONE;
        end
        default: begin
          if (go) begin
            state_q <= ST_RUN;
            rem_q   <= count_i;
            n_o     <= '0;
            ovf_o   <= 1'b0;
          end else if (load_i) begin
            state_q <= ST_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/diff_table_engine.sv
module diff_table_engine
  import diff_eng_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned ORDERS = DEF_ORDERS,
  parameter int unsigned CNT_W  = DEF_CNT_W,
  localparam int unsigned SEL_W = $clog2(ORDERS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [SEL_W-1:0]  load_sel_i,
  input  logic [DATA_W-1:0] load_val_i,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic [DATA_W-1:0] value_o,
  output logic              valid_o,
  output logic [CNT_W-1:0]  index_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              ovf_o
);
  logic [DATA_W-1:0] ord_val [ORDERS+1];
  logic [ORDERS-1:0] carry;
  logic              step, load_ok;
  logic [CNT_W-1:0]  n_cur;

  diff_step_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load_i),
    .start_i     (start_i),
    .count_i     (count_i),
    .carry_any_i (|carry),
    .step_o      (step),
    .load_ok_o   (load_ok),
    .n_o         (n_cur),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .ovf_o       (ovf_o)
  );

  for (genvar k = 0; k <= ORDERS; k++) begin : g_ord
    logic ld_en;
    assign ld_en = load_ok && (load_sel_i == SEL_W'(k));
    if (k < ORDERS) begin : g_add
      diff_order_reg #(.DATA_W(DATA_W)) i_ord (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_en_i  (ld_en),
        .load_val_i (load_val_i),
        .step_i     (step),
        .upper_i    (ord_val[k+1]),
        .val_o      (ord_val[k]),
        .carry_o    (carry[k])
      );
    end else begin : g_top
      // highest order is the constant difference
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    ord_val[k] <= '0;
        else if (ld_en) ord_val[k] <= load_val_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      value_o <= '0;
      index_o <= '0;
    end else begin
      valid_o <= step;
      if (step) begin
        value_o <= ord_val[0];
        index_o <= n_cur;
      end
    end
  end
endmodule

// File: rtl/diff_table_engine_chk.sv
module diff_table_engine_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             load_i,
  input logic             start_i,
  input logic [CNT_W-1:0] count_i,
  input logic             valid_o,
  input logic [CNT_W-1:0] index_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             ovf_o
);
  assert_valid_after_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(busy_o));

  assert_index_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(valid_o)) |-> index_o == CNT_W'($past(index_o) + 1'b1));

  assert_done_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !load_i && !(start_i && count_i != '0)) |=> done_o);

  assert_busy_done_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

  assert_ovf_cleared_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && count_i != '0) |=> !ovf_o);

  assert_zero_count_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && count_i == '0) |=> !busy_o);

  assert_start_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && valid_o && start_i) |=> (valid_o && index_o != '0));
endmodule

bind diff_table_engine diff_table_engine_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .load_i  (load_i),
  .start_i (start_i),
  .count_i (count_i),
  .valid_o (valid_o),
  .index_o (index_o),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .ovf_o   (ovf_o)
);

// File: tb/test_diff_table_engine.sv
`timescale 1ns/1ps
module test_diff_table_engine;
  localparam int W = 48;
  localparam int C = 16;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         load_i = 1'b0;
  logic [2:0]   load_sel_i = '0;
  logic [W-1:0] load_val_i = '0;
  logic         start_i = 1'b0;
  logic [C-1:0] count_i = '0;
  logic [W-1:0] value_o;
  logic         valid_o;
  logic [C-1:0] index_o;
  logic         busy_o, done_o, ovf_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [W-1:0] ref_r [7];
  logic         ref_ovf = 1'b0;
  logic [W-1:0] got [64];

  always #2.5 clk_i = ~clk_i;

  diff_table_engine i_diff_table_engine (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .load_sel_i(load_sel_i),
    .load_val_i(load_val_i), .start_i(start_i), .count_i(count_i),
    .value_o(value_o), .valid_o(valid_o), .index_o(index_o),
    .busy_o(busy_o), .done_o(done_o), .ovf_o(ovf_o)
  );

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic void ref_step();
    logic [W-1:0] nx [7];
    logic [W:0]   s;
    for (int k = 0; k < 6; k++) begin
      s = {1'b0, ref_r[k]} + {1'b0, ref_r[k+1]};
      nx[k] = s[W-1:0];
      if (s[W]) ref_ovf = 1'b1;
    end
    nx[6] = ref_r[6];
    for (int k = 0; k < 7; k++) ref_r[k] = nx[k];
  endfunction

  task automatic ld(input logic [2:0] sel, input logic [W-1:0] val);
    load_i = 1'b1; load_sel_i = sel; load_val_i = val;
    tick();
    load_i = 1'b0;
    if (sel <= 3'd6) ref_r[sel] = val;
  endtask

  task automatic do_run(input int n, input bit disturb, input string req);
    start_i = 1'b1; count_i = C'(n);
    tick();
    start_i = 1'b0;
    ref_ovf = 1'b0;
    chk("R2 busy after start", {63'd0, busy_o}, 64'd1);
    chk("R7 ovf cleared at start", {63'd0, ovf_o}, 64'd0);
    for (int i = 0; i < n; i++) begin
      if (disturb && i == 1) begin
        load_i = 1'b1; load_sel_i = 3'd0; load_val_i = 48'hDEAD_BEEF_0001;
        start_i = 1'b1; count_i = 16'd3;
      end
      tick();
      if (disturb && i == 1) begin
        load_i = 1'b0; start_i = 1'b0;
      end
      chk("R2 valid in run", {63'd0, valid_o}, 64'd1);
      chk("R4 index", {48'd0, index_o}, 64'(i));
      chk(req, {16'd0, value_o}, {16'd0, ref_r[0]});
      chk("R5 done with last", {63'd0, done_o}, {63'd0, (i == n-1)});
      if (i < 64) got[i] = value_o;
      ref_step();
    end
    tick();
    chk("R2 valid falls", {63'd0, valid_o}, 64'd0);
    chk("R5 done held", {63'd0, done_o}, 64'd1);
    chk("R7 ovf flag", {63'd0, ovf_o}, {63'd0, ref_ovf});
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1152));
    for (int k = 0; k < 7; k++) ref_r[k] = '0;
    #12;
    chk("R10 valid", {63'd0, valid_o}, 64'd0);
    chk("R10 done", {63'd0, done_o}, 64'd0);
    chk("R10 busy", {63'd0, busy_o}, 64'd0);
    chk("R10 ovf", {63'd0, ovf_o}, 64'd0);
    chk("R10 value", {16'd0, value_o}, 64'd0);
    chk("R10 index", {48'd0, index_o}, 64'd0);
    rst_ni = 1'b1;
    tick();

    // worked example n^2+n+41
    ld(3'd0, 48'd41); ld(3'd1, 48'd2); ld(3'd2, 48'd2);
    do_run(5, 1'b0, "R3 quadratic table");
    chk("R3 f0", {16'd0, got[0]}, 64'd41);
    chk("R3 f1", {16'd0, got[1]}, 64'd43);
    chk("R3 f2", {16'd0, got[2]}, 64'd47);
    chk("R3 f3", {16'd0, got[3]}, 64'd53);
    chk("R3 f4", {16'd0, got[4]}, 64'd61);

    // continue after done
    do_run(3, 1'b0, "R6 continued table");
    chk("R6 f5", {16'd0, got[0]}, 64'd71);
    chk("R6 f7", {16'd0, got[2]}, 64'd97);

    // zero-count start
    start_i = 1'b1; count_i = '0;
    tick();
    start_i = 1'b0;
    tick();
    chk("R9 no busy", {63'd0, busy_o}, 64'd0);
    chk("R9 no valid", {63'd0, valid_o}, 64'd0);
    chk("R9 done kept", {63'd0, done_o}, 64'd1);
    do_run(2, 1'b0, "R9 state untouched");

    // out-of-range select ignored, load clears done
    ld(3'd7, 48'h1234);
    chk("R1 done cleared by load", {63'd0, done_o}, 64'd0);
    ld(3'd3, 48'd1);
    do_run(6, 1'b1, "R8 mid-run load ignored");

    // single entry
    do_run(1, 1'b0, "R2 single entry");

    // wrap and carry
    ld(3'd0, 48'hFFFF_FFFF_FFFD); ld(3'd1, 48'd2);
    for (int k = 2; k < 7; k++) ld(3'(k), '0);
    do_run(4, 1'b0, "R7 wrap");
    chk("R7 ovf set", {63'd0, ovf_o}, 64'd1);
    chk("R7 wrapped value", {16'd0, got[2]}, 64'd1);
    do_run(2, 1'b0, "R7 no carry run");
    chk("R7 ovf clear", {63'd0, ovf_o}, 64'd0);

    // random sixth-degree tables
    for (int t = 0; t < 12; t++) begin
      for (int k = 0; k < 7; k++) begin
        logic [W-1:0] v;
        v = W'({$urandom, $urandom});
        if (t < 6) v = W'($urandom_range(0, 1000));
        ld(3'(k), v);
      end
      do_run(1 + int'($urandom_range(0, 19)), (t % 3) == 0, "R11 random degree six");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule